// File: doc/BRIEF.md
# Saturating Rounding Variable Shifter

This block is one lane unit of a SIMD datapath. It shifts each element of a 64-bit data word by its own signed count, which it takes from the matching element of a second 64-bit word. A positive count shifts left and clips the lane to its representable range. A negative count shifts right and rounds to nearest. The rounding adder is wider than the lane, so the rounding constant can never wrap the sum. Elements are 16, 32 or 64 bits wide. Each element is read as two's-complement or as unsigned, as the operation requests.

The result is registered and appears one clock after a valid operation. A cumulative saturation flag records that some lane has clipped. The flag is a two-state machine. In FLG_IDLE the flag is low. The transition SET (a valid operation in which any lane saturates) moves it to FLG_STICKY, where the flag is high. The transition CLEAR (sat_clear high, with no saturating operation in the same cycle) returns it to FLG_IDLE. When a saturating operation and a clear arrive in the same cycle, SET wins.

Top module: `qrs_shifter`

## Requirements
- R1: Each lane's shift count is the least significant 8 bits of the matching lane of src_shift, read as a two's-complement value in -128..127. All other bits of that lane are ignored.
- R2: For a count n < 0, the lane result is floor((x + 2^(-n-1)) / 2^(-n)). Here x is the lane read as signed when is_signed=1 (arithmetic shift) and as unsigned when is_signed=0 (logical shift). A right shift never saturates.
- R3: The rounding sum never wraps. An unsigned 64-bit lane of all ones with count -1 gives 0x8000_0000_0000_0000. A signed 64-bit lane of 0x7FFF_FFFF_FFFF_FFFF with count -1 gives 0x4000_0000_0000_0000. A signed 32-bit lane of 0x7FFF_FFFF with count -1 gives 0x4000_0000. An unsigned 16-bit lane of 0xFFFF with count -1 gives 0x8000.
- R4: For a count n >= 0, the lane result is x * 2^n whenever that value fits the lane's range. In that case the lane does not saturate.
- R5: In signed mode, a left shift that does not fit gives the most negative lane value if x is negative, and the most positive lane value otherwise. The lane then saturates.
- R6: In unsigned mode, a left shift that does not fit gives all ones in the lane. The lane then saturates.
- R7: A right-shift count whose magnitude exceeds the lane width gives 0 in both modes.
- R8: A zero lane gives zero for every count and never saturates.
- R9: Saturation in any single lane of a valid operation sets sat_flag (FLG_IDLE to FLG_STICKY) in the next cycle. sat_flag then stays high until it is cleared.
- R10: sat_clear=1 drives sat_flag low in the next cycle, unless a valid operation in that same cycle saturates. In that case the flag is set.
- R11: res_valid goes high exactly one cycle after in_valid, and res_data then holds that operation's result. When in_valid is low, res_data keeps its value. After reset, res_data=0, res_valid=0 and sat_flag=0.
- R12: elem_size selects the lane layout. 2'b00 gives four 16-bit lanes, 2'b01 gives two 32-bit lanes, and 2'b10 or 2'b11 give one 64-bit lane. Lane i occupies bits [i*W +: W] of both src_data and src_shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| is_signed | input | 1 | 1 = two's-complement lanes, 0 = unsigned lanes |
| elem_size | input | 2 | Lane width select (00=16, 01=32, 10/11=64) |
| src_data | input | 64 | Data vector |
| src_shift | input | 64 | Per-lane shift count vector |
| sat_clear | input | 1 | Clear the cumulative saturation flag |
| res_data | output | 64 | Registered result vector |
| res_valid | output | 1 | Result valid, one cycle after in_valid |
| sat_flag | output | 1 | Sticky cumulative saturation flag |

## Verification
Directed vectors place the extreme right-shift cases next to mild rounding cases. These are all-ones and maximum-positive lanes with count -1, next to small values with counts -1 and -2. The pair separates a lane adder that is widened from one that wraps, and an arithmetic right shift from a logical one. Left shifts are tried just inside and just outside each lane's range, in both modes. This shows the back-shift overflow test, the clamp direction for negative inputs, and the unsigned all-ones clamp. Lanes with different counts in one vector, and shift lanes with junk above bit 7, expose a lane boundary or count field taken from the wrong bits. Flag sequences place a single saturating lane, a clear with and without a same-cycle saturation, and idle cycles between them, to tell the sticky state from a per-operation flag. A long run of random operations mixes all sizes and both modes against a wide-integer model.

// File: rtl/qrs_pkg.sv
package qrs_pkg;

    typedef enum logic [1:0] {
        SZ_16 = 2'b00,
        SZ_32 = 2'b01,
        SZ_64 = 2'b10
    } elem_size_e;

    typedef enum logic {
        FLG_IDLE   = 1'b0,
        FLG_STICKY = 1'b1
    } flag_state_e;

endpackage

// File: rtl/qrs_lane.sv
module qrs_lane #(
    parameter int LANE_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic [LANE_W-1:0] x,
    input  logic [LANE_W-1:0] sh,
    input  logic              sgn,
    output logic [LANE_W-1:0] y,
    output logic              sat
);
    localparam int XW = LANE_W + 2;
    localparam int MW = CNT_W + 1;
    localparam logic [MW-1:0] LIM = MW'(LANE_W);

    logic [CNT_W-1:0] cnt;
    logic             unused_hi;
    logic             neg;
    logic [MW-1:0]    mag;

    assign cnt       = sh[CNT_W-1:0];
    assign unused_hi = ^sh[LANE_W-1:CNT_W];
    assign neg       = cnt[CNT_W-1];
    assign mag       = neg ? (MW'(0) - {1'b1, cnt}) : {1'b0, cnt};

    // Right path: rounding sum held two bits wider than the lane.
    logic [XW-1:0]     ext;
    logic [XW-1:0]     rnd;
    logic [XW-1:0]     sum;
    logic [LANE_W-1:0] shr;

    always_comb begin
        ext = {{2{sgn & x[LANE_W-1]}}, x};
        rnd = '0;
        if (mag != '0 && mag <= LIM + MW'(1)) begin
            rnd = XW'(1) << (mag - MW'(1));
        end
        sum = ext + rnd;
        shr = LANE_W'($signed(sum) >>> mag);
    end

    // Left path: overflow if shifting back does not restore the input.
    logic [CNT_W-2:0]  lamt;
    logic [LANE_W-1:0] shl;
    logic [LANE_W-1:0] back;
    logic [LANE_W-1:0] satv;
    logic              lost;

    always_comb begin
        lamt = cnt[CNT_W-2:0];
        shl  = x << lamt;
        back = sgn ? LANE_W'($signed(shl) >>> lamt) : (shl >> lamt);
        lost = (back != x);
        satv = sgn ? {x[LANE_W-1], {(LANE_W-1){~x[LANE_W-1]}}} : '1;
    end

    always_comb begin
        if (neg) begin
            y   = (mag > LIM) ? '0 : shr;
            sat = 1'b0;
        end else begin
            y   = lost ? satv : shl;
            sat = lost;
        end
    end

endmodule

// File: rtl/qrs_flag.sv
module qrs_flag
    import qrs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    flag_state_e st_q;
    flag_state_e st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FLG_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FLG_IDLE:   if (set_i) st_d = FLG_STICKY;
            FLG_STICKY: if (clr_i && !set_i) st_d = FLG_IDLE;
            default:    st_d = FLG_IDLE;
        endcase
    end

    assign flag_o = (st_q == FLG_STICKY);

endmodule

// File: rtl/qrs_shifter.sv
module qrs_shifter
    import qrs_pkg::*;
#(
    parameter int VEC_W = 64,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             is_signed,
    input  logic [1:0]       elem_size,
    input  logic [VEC_W-1:0] src_data,
    input  logic [VEC_W-1:0] src_shift,
    input  logic             sat_clear,
    output logic [VEC_W-1:0] res_data,
    output logic             res_valid,
    output logic             sat_flag
);
    localparam int NSZ = 3;

    logic [VEC_W-1:0] bank_y [NSZ];
    logic [NSZ-1:0]   bank_sat;

    for (genvar g = 0; g < NSZ; g++) begin : g_bank
        localparam int LW = (VEC_W / 4) << g;
        localparam int NL = VEC_W / LW;
        logic [VEC_W-1:0] yb;
        logic [NL-1:0]    ls;
        for (genvar i = 0; i < NL; i++) begin : g_lane
            qrs_lane #(.LANE_W(LW), .CNT_W(CNT_W)) u_lane (
                .x  (src_data[i*LW +: LW]),
                .sh (src_shift[i*LW +: LW]),
                .sgn(is_signed),
                .y  (yb[i*LW +: LW]),
                .sat(ls[i])
            );
        end
        assign bank_y[g]   = yb;
        assign bank_sat[g] = |ls;
    end

    logic [VEC_W-1:0] sel_y;
    logic             sel_sat;

    always_comb begin
        unique case (elem_size)
            SZ_16:   begin sel_y = bank_y[0]; sel_sat = bank_sat[0]; end
            SZ_32:   begin sel_y = bank_y[1]; sel_sat = bank_sat[1]; end
            default: begin sel_y = bank_y[2]; sel_sat = bank_sat[2]; end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_data  <= '0;
            res_valid <= 1'b0;
        end else begin
            res_valid <= in_valid;
            if (in_valid) res_data <= sel_y;
        end
    end

    qrs_flag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (in_valid & sel_sat),
        .clr_i (sat_clear),
        .flag_o(sat_flag)
    );

endmodule

// File: rtl/qrs_checker.sv
module qrs_checker #(
    parameter int VEC_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             is_signed,
    input logic [1:0]       elem_size,
    input logic [VEC_W-1:0] src_data,
    input logic [VEC_W-1:0] src_shift,
    input logic             sat_clear,
    input logic [VEC_W-1:0] res_data,
    input logic             res_valid,
    input logic             sat_flag
);
    localparam logic [VEC_W-1:0] TOP_BIT = {1'b1, {(VEC_W-1){1'b0}}};
    localparam logic [VEC_W-1:0] MAX_POS = {1'b0, {(VEC_W-1){1'b1}}};
    localparam logic [VEC_W-1:0] HALF_TOP = {2'b01, {(VEC_W-2){1'b0}}};

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> res_valid); // R11
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !res_valid); // R11
    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(res_data)); // R11
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_flag && !sat_clear) |=> sat_flag); // R9
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_clear && !in_valid) |=> !sat_flag); // R10
    AST_ZERO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && src_data == '0) |=> (res_data == '0)); // R8
    AST_ZERO_NO_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && src_data == '0 && !sat_flag && !sat_clear) |=> !sat_flag); // R8
    AST_U64_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !is_signed && elem_size == 2'b10 && src_shift[7:0] == 8'hFF
         && src_data == '1) |=> (res_data == TOP_BIT)); // R3
    AST_S64_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_signed && elem_size == 2'b10 && src_shift[7:0] == 8'hFF
         && src_data == MAX_POS) |=> (res_data == HALF_TOP)); // R3

endmodule

bind qrs_shifter qrs_checker #(.VEC_W(VEC_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .is_signed(is_signed),
    .elem_size(elem_size),
    .src_data (src_data),
    .src_shift(src_shift),
    .sat_clear(sat_clear),
    .res_data (res_data),
    .res_valid(res_valid),
    .sat_flag (sat_flag)
);

// File: tb/sim_qrs_shifter.sv
`timescale 1ns/1ps
module sim_qrs_shifter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        is_signed = 1'b0;
    logic [1:0]  elem_size = 2'b00;
    logic [63:0] src_data = '0;
    logic [63:0] src_shift = '0;
    logic        sat_clear = 1'b0;
    logic [63:0] res_data;
    logic        res_valid;
    logic        sat_flag;

    always #2.5 clk = ~clk;

    qrs_shifter u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .is_signed(is_signed),
        .elem_size(elem_size), .src_data(src_data), .src_shift(src_shift),
        .sat_clear(sat_clear), .res_data(res_data), .res_valid(res_valid),
        .sat_flag(sat_flag)
    );

    typedef struct {
        logic [63:0] d;
        logic        f;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   n_tests = 0;
    int   n_fail  = 0;
    logic exp_flag = 1'b0;
    logic [63:0] last_data = '0;
    bit   done = 0;

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic void lane_ref(input logic [63:0] x, input logic [7:0] c,
                                     input int w, input logic sg,
                                     output logic [63:0] y, output logic s);
        logic signed [199:0] v, p, one, hi, lo;
        logic [63:0] mask;
        int n, m;
        one  = 200'sd1;
        mask = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        v = $signed({136'd0, x & mask});
        if (sg && x[w-1]) v = v - (one <<< w);
        n = int'($signed(c));
        s = 1'b0;
        if (n < 0) begin
            m = -n;
            p = (v + (one <<< (m - 1))) >>> m;
            y = p[63:0] & mask;
        end else begin
            p = v <<< n;
            if (sg) begin
                hi = (one <<< (w - 1)) - one;
                lo = -(one <<< (w - 1));
                s  = (p > hi) || (p < lo);
                y  = s ? (x[w-1] ? (64'd1 << (w - 1)) : ((64'd1 << (w - 1)) - 64'd1))
                       : (p[63:0] & mask);
            end else begin
                hi = (one <<< w) - one;
                s  = p > hi;
                y  = s ? mask : (p[63:0] & mask);
            end
        end
    endfunction

    function automatic void vec_ref(input logic [63:0] d, input logic [63:0] sh,
                                    input logic [1:0] sz, input logic sg,
                                    output logic [63:0] y, output logic sat);
        int w, nl;
        logic [63:0] mask, yl;
        logic sl;
        w    = (sz == 2'b00) ? 16 : (sz == 2'b01) ? 32 : 64;
        nl   = 64 / w;
        mask = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        y    = '0;
        sat  = 1'b0;
        for (int i = 0; i < nl; i++) begin
            lane_ref((d >> (i * w)) & mask, 8'((sh >> (i * w)) & 64'hFF), w, sg, yl, sl);
            y   = y | ((yl & mask) << (i * w));
            sat = sat | sl;
        end
    endfunction

    // Driver: presents one operation and queues its expected outcome.
    task automatic op(input logic sg, input logic [1:0] sz, input logic [63:0] d,
                      input logic [63:0] sh, input logic clr, input string tag);
        exp_t e;
        logic [63:0] y;
        logic sat;
        @(negedge clk);
        in_valid  = 1'b1;
        is_signed = sg;
        elem_size = sz;
        src_data  = d;
        src_shift = sh;
        sat_clear = clr;
        vec_ref(d, sh, sz, sg, y, sat);
        exp_flag  = sat ? 1'b1 : (clr ? 1'b0 : exp_flag);
        last_data = y;
        e.d = y; e.f = exp_flag; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid  = 1'b0;
            sat_clear = 1'b0;
        end
    endtask

    task automatic clear_only(input string tag);
        @(negedge clk);
        in_valid  = 1'b0;
        sat_clear = 1'b1;
        exp_flag  = 1'b0;
        @(negedge clk);
        sat_clear = 1'b0;
        check(sat_flag === 1'b0, tag, {63'd0, sat_flag}, 64'd0);
    endtask

    // Monitor: pops the oldest expectation when a result appears.
    always @(negedge clk) begin
        if (res_valid === 1'b1) begin
            if (q.size() == 0) begin
                check(1'b0, "R11 unexpected result", res_data, 64'd0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(res_data === e.d, {e.tag, " data"}, res_data, e.d);
                check(sat_flag === e.f, {e.tag, " flag"}, {63'd0, sat_flag}, {63'd0, e.f});
            end
        end
    end

    initial begin
        #500000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(res_data === 64'd0, "R11 reset data", res_data, 64'd0);
        check(res_valid === 1'b0, "R11 reset valid", {63'd0, res_valid}, 64'd0);
        check(sat_flag === 1'b0, "R11 reset flag", {63'd0, sat_flag}, 64'd0);

        // R8: zero input, any counts, no saturation
        op(1'b1, 2'b00, 64'd0, 64'h7F10_0F40_0080_00FF, 1'b0, "R8 zero s16");
        op(1'b0, 2'b10, 64'd0, 64'h0000_0000_0000_007F, 1'b0, "R8 zero u64");
        idle(1);
        check(sat_flag === 1'b0, "R8 no sat on zero", {63'd0, sat_flag}, 64'd0);

        // R1: count from low byte only
        op(1'b1, 2'b00, 64'h0001_0001_0001_0003, 64'h0000_7F01_AB02_FF01, 1'b0, "R1 low byte s16");
        // R12: layouts
        op(1'b0, 2'b10, 64'h0000_0000_0000_00F0, 64'h1234_5678_9ABC_01FC, 1'b0, "R12 u64 size10");
        op(1'b0, 2'b11, 64'h0000_0000_0000_00F0, 64'h1234_5678_9ABC_01FC, 1'b0, "R12 u64 size11");
        op(1'b1, 2'b01, 64'h0000_0100_FFFF_FF00, 64'h0000_00FC_0000_0002, 1'b0, "R12 s32 lanes");
        // R2: rounding right shifts
        op(1'b1, 2'b00, 64'hFFF5_0005_8000_0006, 64'h00FF_00FE_00F1_00FF, 1'b0, "R2 s16 round");
        op(1'b0, 2'b01, 64'hFFFF_FFF5_0000_0006, 64'h0000_00FE_0000_00FF, 1'b0, "R2 u32 logical");
        op(1'b1, 2'b01, 64'hFFFF_FFF5_8000_0001, 64'h0000_00FE_0000_00E1, 1'b0, "R2 s32 arith");
        idle(1);

        // R3: no wrap, explicit constants
        op(1'b0, 2'b10, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_00FF, 1'b0, "R3 u64 ones");
        idle(1);
        check(res_data === 64'h8000_0000_0000_0000, "R3 u64 const", res_data, 64'h8000_0000_0000_0000);
        op(1'b1, 2'b10, 64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_00FF, 1'b0, "R3 s64 max");
        idle(1);
        check(res_data === 64'h4000_0000_0000_0000, "R3 s64 const", res_data, 64'h4000_0000_0000_0000);
        op(1'b1, 2'b01, 64'h7FFF_FFFF_7FFF_FFFF, 64'h0000_00FF_0000_00FF, 1'b0, "R3 s32 max");
        idle(1);
        check(res_data === 64'h4000_0000_4000_0000, "R3 s32 const", res_data, 64'h4000_0000_4000_0000);
        op(1'b0, 2'b00, 64'hFFFF_FFFF_FFFF_FFFF, 64'h00FF_00FF_00FF_00FF, 1'b0, "R3 u16 ones");
        idle(1);
        check(res_data === 64'h8000_8000_8000_8000, "R3 u16 const", res_data, 64'h8000_8000_8000_8000);

        // R4: left shifts that fit
        op(1'b1, 2'b01, 64'hFFFF_FFFD_0000_0123, 64'h0000_0004_0000_0008, 1'b0, "R4 s32 fit");
        op(1'b0, 2'b10, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_003F, 1'b0, "R4 u64 top");
        op(1'b1, 2'b00, 64'hC000_0001_0003_7FFF, 64'h0001_000E_0002_0000, 1'b0, "R4 s16 edge");
        idle(1);
        check(sat_flag === 1'b0, "R4 no sat", {63'd0, sat_flag}, 64'd0);

        // R5: signed clamp
        op(1'b1, 2'b00, 64'h4000_BFFF_0001_8000, 64'h0001_0001_000F_0001, 1'b0, "R5 s16 clamp");
        clear_only("R10 clear idle");
        op(1'b1, 2'b10, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0040, 1'b0, "R5 s64 neg clamp");
        op(1'b1, 2'b10, 64'h0000_0000_0000_0003, 64'h0000_0000_0000_003E, 1'b0, "R5 s64 pos clamp");
        idle(1);
        check(res_data === 64'h7FFF_FFFF_FFFF_FFFF, "R5 s64 max const", res_data, 64'h7FFF_FFFF_FFFF_FFFF);
        clear_only("R10 clear after R5");

        // R6: unsigned clamp
        op(1'b0, 2'b01, 64'h8000_0001_0000_0001, 64'h0000_0001_0000_0028, 1'b0, "R6 u32 clamp");
        clear_only("R10 clear after R6");

        // R7: huge right counts
        op(1'b1, 2'b10, 64'h8000_0000_0000_0000, 64'h0000_0000_0000_0080, 1'b0, "R7 s64 -128");
        idle(1);
        check(res_data === 64'd0, "R7 s64 zero", res_data, 64'd0);
        op(1'b0, 2'b10, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_00BA, 1'b0, "R7 u64 -70");
        op(1'b1, 2'b00, 64'h8000_FFFF_7FFF_8000, 64'h00EF_00EF_00EF_0080, 1'b0, "R7 s16 -17");
        op(1'b0, 2'b00, 64'hFFFF_FFFF_FFFF_FFFF, 64'h00EF_00F0_0080_00EF, 1'b0, "R7 u16 mixed");
        idle(1);
        check(res_data === 64'h0000_0001_0000_0000, "R7 u16 const", res_data, 64'h0000_0001_0000_0000);

        // R9: single lane saturates, flag sticks through clean ops and idle
        op(1'b1, 2'b00, 64'h4000_0001_0001_0001, 64'h0004_0001_0001_0001, 1'b0, "R9 one lane");
        op(1'b1, 2'b00, 64'h0001_0001_0001_0001, 64'h0001_0001_0001_0001, 1'b0, "R9 sticky op");
        idle(4);
        check(sat_flag === 1'b1, "R9 sticky idle", {63'd0, sat_flag}, 64'd1);
        // R11: hold while idle
        check(res_data === last_data, "R11 hold", res_data, last_data);
        check(res_valid === 1'b0, "R11 idle valid", {63'd0, res_valid}, 64'd0);

        // R10: clear with clean op, clear with saturating op
        op(1'b0, 2'b01, 64'h0000_0001_0000_0001, 64'h0000_0001_0000_0001, 1'b1, "R10 clear with op");
        op(1'b0, 2'b01, 64'hFFFF_FFFF_0000_0001, 64'h0000_0001_0000_0001, 1'b1, "R10 set wins");
        idle(1);
        check(sat_flag === 1'b1, "R10 set wins flag", {63'd0, sat_flag}, 64'd1);
        clear_only("R10 clear final");

        // Random mix (R2 R4 R5 R6 R12)
        for (int k = 0; k < 400; k++) begin
            logic [63:0] d, sh;
            logic [1:0] sz;
            d  = {$urandom(), $urandom()};
            if (k % 5 == 0) d = d >> ($urandom_range(0, 63));
            sz = 2'($urandom_range(0, 3));
            sh = '0;
            for (int j = 0; j < 4; j++) begin
                logic [7:0] c;
                c = (k % 7 == 0) ? 8'($urandom()) : 8'($urandom_range(0, 80) - 40);
                sh[j*16 +: 16] = {8'($urandom()), c};
            end
            op(1'($urandom()), sz, d, sh, ($urandom_range(0, 7) == 0), "R12 random");
        end
        idle(3);
        check(q.size() == 0, "R11 all results seen", 64'(q.size()), 64'd0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule